// File: doc/BRIEF.md
# Quad SPI Target to Stream Bridge

This block lets an external quad SPI host reach on-chip stream traffic. The host lowers chip select and shifts in an 8-bit opcode on IO0 only. The opcode picks one of two directions. In a quad write, every later rising SCK edge carries a nibble on all four IO lines, and each pair of nibbles leaves as one byte on a stream master port. In a quad read, the host first clocks a fixed number of dummy cycles. During these the bridge prefetches a byte from a stream slave port. It then returns bytes four bits per SCK cycle, driving the IO lines itself.

All pad inputs are oversampled in the system clock domain through two-flop synchronisers, and SCK and chip-select edges are found there. The system clock must therefore run at least four times faster than SCK. The bridge drives the IO output enables itself. It releases them whenever it is not returning read data.

Top module: `qspi_stream_bridge`

## Requirements
- R1: A falling edge on `csn_i` opens a transaction. A rising edge on `csn_i` closes it at any point, and the block then waits idle for the next falling edge.
- R2: Input bits are taken only on rising SCK edges while `csn_i` is low. SCK activity with `csn_i` high produces no stream beat and no output enable.
- R3: The first 8 rising SCK edges of a transaction shift in an opcode from IO0, most significant bit first. Opcode 0x38 selects quad write and opcode 0xEB selects quad read. The bit-reversed values of these opcodes are not recognised.
- R4: In a quad write, each later rising SCK edge captures `io_i[3:0]` as one nibble. The first nibble of each pair forms bits 7:4 of a byte, and each completed byte appears on `m_tdata` in arrival order.
- R5: The most recent complete byte is held back until the transaction ends or the next byte completes. `m_tlast` is 1 only on the final complete byte, which is issued after `csn_i` rises. A trailing odd nibble is discarded.
- R6: Once `m_tvalid` is high, it stays high with `m_tdata` and `m_tlast` unchanged until a cycle with `m_tready` high. The sink must accept each byte within roughly two SCK periods.
- R7: `io_oe` is 0 after reset and during the opcode, write, dummy and ignored phases. It returns to 0 within a few system clocks of `csn_i` rising.
- R8: In a quad read, `DUMMY_CYCLES` rising SCK edges follow the opcode. `s_tready` is high while the one-byte prefetch buffer is empty, during the dummy and data phases only.
- R9: After the dummy phase, each falling SCK edge drives a new nibble on `io_o` with `io_oe` = 4'hF. The high nibble comes first, and the nibble holds until the next falling edge. Successive bytes follow stream order.
- R10: If no stream byte is held or offered when a byte slot begins, the block returns 0xFF for that slot.
- R11: After an unrecognised opcode, the rest of the transaction is ignored. No beat is issued, no byte is fetched and `io_oe` stays 0, and the next transaction works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low chip select from the host |
| io_i | input | 4 | IO pad input values |
| io_o | output | 4 | IO pad output values |
| io_oe | output | 4 | IO pad output enables, 1 drives |
| m_tdata | output | 8 | Write-direction stream data |
| m_tvalid | output | 1 | Write-direction stream valid |
| m_tready | input | 1 | Write-direction stream ready |
| m_tlast | output | 1 | Marks the final byte of a write transaction |
| s_tdata | input | 8 | Read-direction stream data |
| s_tvalid | input | 1 | Read-direction stream valid |
| s_tready | output | 1 | Read-direction stream ready |

## Verification
On the write side, a newly completed byte can move into the output register in the same cycle that the sink accepts the byte already held there. The bench sweeps the sink's stall length from zero to several cycles over many byte counts, so that the handshake lands before, on and after the byte-completion cycle. It checks every received byte against an arithmetic pattern and checks that data stays stable while stalled. On the read side, a stream byte can arrive in the same cycle that a byte slot begins. A late-source case provokes this: the source starts offering data only after the first slot has begun. The bench expects 0xFF followed by the stream bytes in order.

// File: rtl/qsb_pkg.sv
package qsb_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_QUAD_WRITE = 8'h38;
    localparam logic [BYTE_W-1:0] OP_QUAD_READ  = 8'hEB;
    localparam logic [BYTE_W-1:0] EMPTY_FILL    = 8'hFF;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_WDATA,
        PH_DUMMY,
        PH_RDATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              last;
    } beat_t;

    function automatic phase_e decode_op(input logic [BYTE_W-1:0] op);
        case (op)
            OP_QUAD_WRITE: decode_op = PH_WDATA;
            OP_QUAD_READ:  decode_op = PH_DUMMY;
            default:       decode_op = PH_SKIP;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] join_nibbles(input logic [NIB_W-1:0] hi,
                                                       input logic [NIB_W-1:0] lo);
        join_nibbles = {hi, lo};
    endfunction

endpackage

// File: rtl/qsb_sync.sv
module qsb_sync #(
    parameter int              W       = 4,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/qsb_edge.sv
module qsb_edge #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= lvl;
    end

    for (genvar g = 0; g < W; g++) begin : g_edge
        assign rise[g] =  lvl[g] & ~prev_q[g];
        assign fall[g] = ~lvl[g] &  prev_q[g];
    end
endmodule

// File: rtl/qsb_ctrl.sv
module qsb_ctrl
    import qsb_pkg::*;
#(
    parameter int DUMMY_CYCLES = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   txn_open,
    input  logic   txn_close,
    input  logic   sck_rise,
    input  logic   io0,
    output phase_e phase
);
    localparam int CNT_W = (DUMMY_CYCLES > 1) ? $clog2(DUMMY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_CYCLES - 1);
    localparam logic [2:0]       OP_LAST_BIT = 3'd7;

    phase_e            phase_q;
    logic [BYTE_W-1:0] op_sr_q;
    logic [BYTE_W-1:0] op_next;
    logic [2:0]        bit_cnt_q;
    logic [CNT_W-1:0]  dum_cnt_q;

    assign op_next = {op_sr_q[BYTE_W-2:0], io0};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            op_sr_q   <= '0;
            bit_cnt_q <= '0;
            dum_cnt_q <= '0;
        end else if (txn_close) begin
            phase_q <= PH_IDLE;
        end else if (txn_open) begin
            phase_q   <= PH_CMD;
            bit_cnt_q <= '0;
            dum_cnt_q <= '0;
        end else if (sck_rise) begin
            case (phase_q)
                PH_CMD: begin
                    op_sr_q <= op_next;
                    if (bit_cnt_q == OP_LAST_BIT) phase_q <= decode_op(op_next);
                    else                          bit_cnt_q <= bit_cnt_q + 3'd1;
                end
                PH_DUMMY: begin
                    if (dum_cnt_q == DUMMY_LAST) phase_q   <= PH_RDATA;
                    else                         dum_cnt_q <= dum_cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign phase = phase_q;

    AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        txn_close |=> (phase_q == PH_IDLE)); // R1

    AST_SKIP_STICKS: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SKIP && !txn_close) |=> (phase_q == PH_SKIP)); // R11
endmodule

// File: rtl/qsb_wr_path.sv
module qsb_wr_path
    import qsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_open,
    input  logic              txn_close,
    input  logic              cap_en,
    input  logic [NIB_W-1:0]  nib_in,
    input  logic              m_tready,
    output logic [BYTE_W-1:0] m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast
);
    logic [NIB_W-1:0]  hi_q;
    logic              half_q;
    logic [BYTE_W-1:0] pend_q;
    logic              pend_v_q;
    beat_t             out_q;
    logic              out_v_q;
    logic              byte_done;
    logic              push;

    assign byte_done = cap_en && half_q;
    assign push      = pend_v_q && (byte_done || txn_close);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q     <= '0;
            half_q   <= 1'b0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            out_q    <= '0;
            out_v_q  <= 1'b0;
        end else begin
            if (out_v_q && m_tready) out_v_q <= 1'b0;
            if (push) begin
                out_q.data <= pend_q;
                out_q.last <= txn_close;
                out_v_q    <= 1'b1;
            end
            if (txn_open || txn_close) begin
                half_q   <= 1'b0;
                pend_v_q <= 1'b0;
            end else if (cap_en) begin
                if (!half_q) begin
                    hi_q   <= nib_in;
                    half_q <= 1'b1;
                end else begin
                    pend_q   <= join_nibbles(hi_q, nib_in);
                    pend_v_q <= 1'b1;
                    half_q   <= 1'b0;
                end
            end
        end
    end

    assign m_tdata  = out_q.data;
    assign m_tlast  = out_q.last;
    assign m_tvalid = out_v_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !(m_tvalid && !m_tready)); // R6

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast))); // R6
endmodule

// File: rtl/qsb_rd_path.sv
module qsb_rd_path
    import qsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_open,
    input  logic              txn_close,
    input  logic              dummy_ph,
    input  logic              rdata_ph,
    input  logic              sck_fall,
    input  logic [BYTE_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [NIB_W-1:0]  io_o,
    output logic [NIB_W-1:0]  io_oe
);
    logic [BYTE_W-1:0] pf_data_q;
    logic              pf_v_q;
    logic [NIB_W-1:0]  lo_q;
    logic              lo_pend_q;
    logic [NIB_W-1:0]  nib_q;
    logic              drv_q;
    logic              pop;
    logic              slot_start;
    logic [BYTE_W-1:0] slot_byte;

    assign s_tready   = (dummy_ph || rdata_ph) && !pf_v_q && !txn_close;
    assign pop        = s_tvalid && s_tready;
    assign slot_start = rdata_ph && sck_fall && !lo_pend_q;
    assign slot_byte  = pf_v_q ? pf_data_q : (pop ? s_tdata : EMPTY_FILL);

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_data_q <= '0;
            pf_v_q    <= 1'b0;
            lo_q      <= '0;
            lo_pend_q <= 1'b0;
            nib_q     <= '0;
            drv_q     <= 1'b0;
        end else if (txn_open || txn_close) begin
            pf_v_q    <= 1'b0;
            lo_pend_q <= 1'b0;
            nib_q     <= '0;
            drv_q     <= 1'b0;
        end else if (slot_start) begin
            nib_q     <= slot_byte[BYTE_W-1:NIB_W];
            lo_q      <= slot_byte[NIB_W-1:0];
            lo_pend_q <= 1'b1;
            drv_q     <= 1'b1;
            pf_v_q    <= 1'b0;
        end else begin
            if (rdata_ph && sck_fall && lo_pend_q) begin
                nib_q     <= lo_q;
                lo_pend_q <= 1'b0;
            end
            if (pop) begin
                pf_data_q <= s_tdata;
                pf_v_q    <= 1'b1;
            end
        end
    end

    assign io_o  = nib_q;
    assign io_oe = {NIB_W{drv_q}};

    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        !rdata_ph |=> (io_oe == '0)); // R7

    AST_NIBBLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sck_fall && !txn_open && !txn_close) |=> $stable(io_o)); // R9
endmodule

// File: rtl/qspi_stream_bridge.sv
module qspi_stream_bridge
    import qsb_pkg::*;
#(
    parameter int DUMMY_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sck_i,
    input  logic        csn_i,
    input  logic [3:0]  io_i,
    output logic [3:0]  io_o,
    output logic [3:0]  io_oe,
    output logic [7:0]  m_tdata,
    output logic        m_tvalid,
    input  logic        m_tready,
    output logic        m_tlast,
    input  logic [7:0]  s_tdata,
    input  logic        s_tvalid,
    output logic        s_tready
);
    localparam int SYNC_W = NIB_W + 2;
    localparam int CSN_B  = SYNC_W - 1;
    localparam int SCK_B  = SYNC_W - 2;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, 1'b0, {NIB_W{1'b0}}};
    localparam logic [1:0]        EDGE_RST = 2'b10;

    logic [SYNC_W-1:0] pins_sync;
    logic [1:0]        ctl_rise;
    logic [1:0]        ctl_fall;
    logic              txn_open;
    logic              txn_close;
    logic              sck_rise;
    logic              sck_fall;
    phase_e            phase;

    qsb_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({csn_i, sck_i, io_i}),
        .dout (pins_sync)
    );

    qsb_edge #(.W(2), .RST_VAL(EDGE_RST)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({pins_sync[CSN_B], pins_sync[SCK_B]}),
        .rise (ctl_rise),
        .fall (ctl_fall)
    );

    assign txn_open  = ctl_fall[1];
    assign txn_close = ctl_rise[1];
    assign sck_rise  = ctl_rise[0];
    assign sck_fall  = ctl_fall[0];

    qsb_ctrl #(.DUMMY_CYCLES(DUMMY_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .txn_open  (txn_open),
        .txn_close (txn_close),
        .sck_rise  (sck_rise),
        .io0       (pins_sync[0]),
        .phase     (phase)
    );

    qsb_wr_path u_wr (
        .clk       (clk),
        .rst       (rst),
        .txn_open  (txn_open),
        .txn_close (txn_close),
        .cap_en    (sck_rise && phase == PH_WDATA),
        .nib_in    (pins_sync[NIB_W-1:0]),
        .m_tready  (m_tready),
        .m_tdata   (m_tdata),
        .m_tvalid  (m_tvalid),
        .m_tlast   (m_tlast)
    );

    qsb_rd_path u_rd (
        .clk       (clk),
        .rst       (rst),
        .txn_open  (txn_open),
        .txn_close (txn_close),
        .dummy_ph  (phase == PH_DUMMY),
        .rdata_ph  (phase == PH_RDATA),
        .sck_fall  (sck_fall),
        .s_tdata   (s_tdata),
        .s_tvalid  (s_tvalid),
        .s_tready  (s_tready),
        .io_o      (io_o),
        .io_oe     (io_oe)
    );
endmodule

// File: tb/qspi_stream_bridge_tb.sv
`timescale 1ns/1ps
module qspi_stream_bridge_tb;
    localparam int DUMMY = 4;
    localparam int HOLD  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       csn = 1'b1;
    logic [3:0] io_drv = 4'h0;
    logic [3:0] io_o, io_oe;
    logic [7:0] m_tdata;
    logic       m_tvalid, m_tlast;
    logic       m_tready = 1'b0;
    logic [7:0] s_tdata = 8'h00;
    logic       s_tvalid = 1'b0;
    logic       s_tready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] rec_data [0:1023];
    logic       rec_last [0:1023];
    int rec_n = 0;
    int stall_len = 0;
    int wait_cnt = 0;
    logic [8:0] held = '0;

    bit src_en = 1'b0;
    int src_n = 0;
    int src_start = 0;
    int src_pop = 0;

    always #2 clk = ~clk;

    qspi_stream_bridge #(.DUMMY_CYCLES(DUMMY)) u_dut (
        .clk(clk), .rst(rst), .sck_i(sck), .csn_i(csn), .io_i(io_drv),
        .io_o(io_o), .io_oe(io_oe),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wbyte(input int t, input int i);
        return 8'((t * 41 + i * 13 + 5) & 255);
    endfunction

    function automatic logic [7:0] sbyte(input int i);
        return 8'((i * 29 + 7) & 255);
    endfunction

    // Sink: decides ready for the coming edge and records accepted beats
    always @(negedge clk) begin
        if (m_tvalid && wait_cnt > 0)
            chk("R6 stalled beat stable", int'({m_tdata, m_tlast}), int'(held));
        if (m_tvalid && wait_cnt >= stall_len) begin
            m_tready = 1'b1;
            rec_data[rec_n % 1024] = m_tdata;
            rec_last[rec_n % 1024] = m_tlast;
            rec_n++;
            wait_cnt = 0;
        end else begin
            m_tready = 1'b0;
            if (m_tvalid) begin
                if (wait_cnt == 0) held = {m_tdata, m_tlast};
                wait_cnt++;
            end
        end
    end

    // Source: offers bytes of a pattern and counts accepted ones
    always @(negedge clk) begin
        s_tvalid = src_en && ((src_pop - src_start) < src_n);
        s_tdata  = sbyte(src_pop);
        if (s_tvalid && s_tready) src_pop++;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        sck = 1'b1;
        wait_clk(HOLD);
        sck = 1'b0;
        wait_clk(HOLD);
    endtask

    task automatic send_op(input logic [7:0] op);
        for (int b = 7; b >= 0; b--) begin
            io_drv = {3'b101, op[b]};
            wait_clk(HOLD);
            pulse();
        end
    endtask

    task automatic wr_txn(input int nbytes, input int odd, input int stall, input int t);
        int base;
        int got;
        base = rec_n;
        stall_len = stall;
        csn = 1'b0;
        wait_clk(HOLD);
        send_op(8'h38);
        chk("R7 oe off after opcode", int'(io_oe), 0);
        for (int i = 0; i < nbytes; i++) begin
            io_drv = wbyte(t, i)[7:4];
            wait_clk(HOLD);
            pulse();
            io_drv = wbyte(t, i)[3:0];
            wait_clk(HOLD);
            pulse();
        end
        if (odd != 0) begin
            io_drv = 4'hA;
            wait_clk(HOLD);
            pulse();
        end
        wait_clk(24);
        chk("R7 oe off in write", int'(io_oe), 0);
        chk("R5 last byte held until end", rec_n - base, (nbytes > 0) ? nbytes - 1 : 0);
        csn = 1'b1;
        wait_clk(40);
        got = rec_n - base;
        chk("R4 byte count", got, nbytes);
        for (int i = 0; i < nbytes && i < got; i++) begin
            chk("R4 byte value", int'(rec_data[(base + i) % 1024]), int'(wbyte(t, i)));
            chk("R5 last flag", int'(rec_last[(base + i) % 1024]), (i == nbytes - 1) ? 1 : 0);
        end
    endtask

    task automatic rd_txn(input int nbytes, input int avail, input bit late);
        logic [7:0] exp;
        src_start = src_pop;
        src_n = avail;
        src_en = !late;
        csn = 1'b0;
        wait_clk(HOLD);
        send_op(8'hEB);
        chk("R7 oe off after read opcode", int'(io_oe), 0);
        pulse();
        pulse();
        chk("R8 prefetch during dummy", src_pop - src_start, (!late && avail > 0) ? 1 : 0);
        chk("R8 ready while buffer empty", int'(s_tready), (late || avail == 0) ? 1 : 0);
        chk("R7 oe off in dummy", int'(io_oe), 0);
        for (int d = 2; d < DUMMY; d++) pulse();
        for (int k = 0; k < nbytes; k++) begin
            if (late) exp = (k == 0 || k - 1 >= avail) ? 8'hFF : sbyte(src_start + k - 1);
            else      exp = (k >= avail) ? 8'hFF : sbyte(src_start + k);
            chk("R9 oe driven", int'(io_oe), 15);
            chk((exp == 8'hFF) ? "R10 fill high nibble" : "R9 high nibble", int'(io_o), int'(exp[7:4]));
            if (late && k == 0) src_en = 1'b1;
            pulse();
            chk((exp == 8'hFF) ? "R10 fill low nibble" : "R9 low nibble", int'(io_o), int'(exp[3:0]));
            pulse();
        end
        csn = 1'b1;
        wait_clk(6);
        chk("R7 oe released after end", int'(io_oe), 0);
        chk("R8 ready low when idle", int'(s_tready), 0);
        src_en = 1'b0;
        wait_clk(20);
    endtask

    task automatic skip_txn();
        int base;
        int pop0;
        base = rec_n;
        pop0 = src_pop;
        src_start = src_pop;
        src_n = 4;
        src_en = 1'b1;
        csn = 1'b0;
        wait_clk(HOLD);
        send_op(8'h1C);
        for (int j = 0; j < 6; j++) begin
            io_drv = 4'(j * 5 + 3);
            wait_clk(HOLD);
            pulse();
            chk("R11 oe stays off", int'(io_oe), 0);
        end
        chk("R11 no fetch ready", int'(s_tready), 0);
        csn = 1'b1;
        wait_clk(40);
        chk("R11 no beats", rec_n - base, 0);
        chk("R3 R11 no bytes fetched", src_pop - pop0, 0);
        src_en = 1'b0;
    endtask

    initial begin
        int t;
        t = 0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        chk("R1 reset no beat", int'(m_tvalid), 0);
        chk("R7 reset oe", int'(io_oe), 0);
        chk("R8 reset ready", int'(s_tready), 0);

        // R2: clocking with chip select high is inert
        for (int j = 0; j < 10; j++) begin
            io_drv = 4'(j * 7);
            wait_clk(HOLD);
            pulse();
        end
        wait_clk(20);
        chk("R2 no beats while deselected", rec_n, 0);
        chk("R2 oe off while deselected", int'(io_oe), 0);

        for (int nb = 0; nb <= 4; nb++)
            for (int odd = 0; odd <= 1; odd++)
                for (int si = 0; si <= 5; si++) begin
                    wr_txn(nb, odd, (si == 5) ? 11 : si, t);
                    t++;
                    wait_clk(10);
                end

        for (int nb = 1; nb <= 3; nb++)
            for (int av = 0; av <= 3; av++)
                rd_txn(nb, av, 1'b0);
        rd_txn(3, 2, 1'b1);

        skip_txn();
        wr_txn(3, 0, 2, t);
        rd_txn(2, 2, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule